// File: doc/BRIEF.md
# MSI Doorbell Frame to SPI Edge Translator

This block is a small memory-mapped doorbell frame. A message-signalled interrupt arrives as a single 32-bit register write. The frame decodes which shared peripheral interrupt (SPI) that write names, checks the number against a window of SPIs fixed at elaboration, and raises a one-cycle rising-edge pulse on the matching bit of its output vector. An interrupt distributor downstream samples that vector. Masking, priority and security banking are left to that distributor.

Four decoding variants can be selected at elaboration:
- **Absolute:** the write data is the absolute SPI number.
- **Base-relative:** the write data is the SPI number less the window base.
- **Fixed-offset:** the write data is the SPI number less 32.
- **Address-only:** the SPI comes from the write offset, with eight bytes per SPI starting at SPI 32. The frame then spans 8 KiB and the data is ignored.

Software can read two constant registers. One describes the window and one identifies the frame. A status register records decoded numbers that fell outside the window.

The window must start at SPI 32 or above. It must not be empty, and base plus count must not exceed 1019. Elaboration stops on any other setting. Every bus access receives a one-cycle ready response on the cycle after the strobe.

Top module: `msi_spi_frame`

## Requirements
- R1: A read at offset 0x008 returns the window description: base SPI in bits [25:16], SPI count in bits [9:0], zeros in bits [31:26] and [15:10].
- R2: A read at offset 0xFCC returns the identification parameter. A read of any offset other than 0x008, 0x00C and 0xFCC returns zero. In the three data-decoding variants, writes to these read-only offsets leave their contents unchanged.
- R3: In the absolute variant (mode 0), a write at offset 0x040 targets the SPI whose number equals the write data.
- R4: In the base-relative variant (mode 1), a write at offset 0x040 targets SPI (write data + base).
- R5: In the fixed-offset variant (mode 2), a write at offset 0x040 targets SPI (write data + 32).
- R6: In the address-only variant (mode 3), a write at any 8-byte-aligned offset A targets SPI (A >> 3) + 32, whatever the data. A write whose offset bits [2:0] are not zero has no effect. In the other variants, writes to offsets other than 0x040 have no effect.
- R7: A write that targets an SPI inside [base, base+count-1] raises output bit (SPI - base) for exactly one cycle. That cycle is the one in which the write's ready is high.
- R8: A write that targets an SPI outside the window raises no output bit. It is answered with the error response high together with ready.
- R9: Bit 0 of the status register at offset 0x00C becomes 1 after any out-of-window write and stays 1. A read of 0x00C returns the flag and then clears it.
- R10: Writes on consecutive cycles each produce their own pulse. Two consecutive writes to the same SPI give two one-cycle pulses separated by one low cycle.
- R11: Every cycle with a write or read strobe is followed by exactly one ready cycle, and no ready appears otherwise. When both strobes are high, only the write takes effect and the read data is zero.
- R12: While reset is held, ready, the error response, the read data and all pulse outputs are zero, and the status flag is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 13 | Byte offset within the frame |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with ready |
| bus_ready | output | 1 | Access completion, one cycle after the strobe |
| bus_err | output | 1 | Error response for an out-of-window doorbell write |
| spi_pulse | output | NUM_SPI | Rising-edge events, bit i is SPI base+i |

## Verification
A fault in the decode path shows at the ports on the cycle right after the write: the wrong bit pulses, or the error response appears where a pulse was expected. A pending bit stuck set shows within two cycles as an extra pulse, or as a pulse held high for two cycles. A wrong status flag is hidden until the next read of offset 0x00C, so the stimulus reads that register often and after every class of error. The same writes go to one instance of each variant, so the same bus traffic checks all four decodings.

// File: rtl/msi_frame_pkg.sv
package msi_frame_pkg;

  // Decoding variant selected at elaboration
  typedef enum logic [1:0] {
    DEC_ABSOLUTE  = 2'd0,
    DEC_BASE_REL  = 2'd1,
    DEC_FIXED32   = 2'd2,
    DEC_ADDR_ONLY = 2'd3
  } dec_mode_e;

  localparam int ADDR_W   = 13;
  localparam int DATA_W   = 32;
  localparam int SPI_LOW  = 32;
  localparam int SPI_HIGH = 1019;

  localparam logic [ADDR_W-1:0] OFF_TYPE     = 13'h008;
  localparam logic [ADDR_W-1:0] OFF_STATUS   = 13'h00C;
  localparam logic [ADDR_W-1:0] OFF_DOORBELL = 13'h040;
  localparam logic [ADDR_W-1:0] OFF_IDENT    = 13'hFCC;

endpackage

// File: rtl/msi_db_decode.sv
module msi_db_decode
  import msi_frame_pkg::*;
#(
  parameter dec_mode_e MODE     = DEC_ABSOLUTE,
  parameter int        BASE_SPI = 96,
  parameter int        NUM_SPI  = 64,
  parameter int        IDX_W    = 6
) (
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              db_hit,
  output logic              db_miss,
  output logic [IDX_W-1:0]  db_idx
);

  localparam logic [DATA_W:0] WIN_LO = (DATA_W+1)'(BASE_SPI);
  localparam logic [DATA_W:0] WIN_HI = (DATA_W+1)'(BASE_SPI + NUM_SPI - 1);

  logic [DATA_W:0] num_abs;
  logic [DATA_W:0] num_rel;
  logic [DATA_W:0] num_f32;
  logic [DATA_W:0] num_adr;
  logic [DATA_W:0] spi_num;
  logic            is_db;
  logic            in_win;

  // One extra bit keeps data + offset from wrapping into the window
  always_comb begin
    num_abs = {1'b0, wdata};
    num_rel = {1'b0, wdata} + WIN_LO;
    num_f32 = {1'b0, wdata} + (DATA_W+1)'(SPI_LOW);
    num_adr = (DATA_W+1)'(addr[ADDR_W-1:3]) + (DATA_W+1)'(SPI_LOW);
  end

  always_comb begin
    spi_num = num_abs;
    is_db   = wr_en && (addr == OFF_DOORBELL);
    case (MODE)
      DEC_ABSOLUTE:  spi_num = num_abs;
      DEC_BASE_REL:  spi_num = num_rel;
      DEC_FIXED32:   spi_num = num_f32;
      DEC_ADDR_ONLY: begin
        spi_num = num_adr;
        is_db   = wr_en && (addr[2:0] == 3'd0);
      end
      default:       spi_num = num_abs;
    endcase
  end

  always_comb begin
    in_win  = (spi_num >= WIN_LO) && (spi_num <= WIN_HI);
    db_hit  = is_db && in_win;
    db_miss = is_db && !in_win;
    db_idx  = IDX_W'(spi_num - WIN_LO);
  end

endmodule

// File: rtl/msi_edge_gen.sv
module msi_edge_gen #(
  parameter int NUM_SPI = 64,
  parameter int IDX_W   = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fire,
  input  logic [IDX_W-1:0]   idx,
  output logic [NUM_SPI-1:0] pulse
);

  logic [NUM_SPI-1:0] hit_vec;
  logic [NUM_SPI-1:0] req_vec;
  logic [NUM_SPI-1:0] pulse_q;
  logic [NUM_SPI-1:0] pulse_nxt;
  logic [NUM_SPI-1:0] pend_q;
  logic [NUM_SPI-1:0] pend_nxt;

  for (genvar i = 0; i < NUM_SPI; i++) begin : g_line
    assign hit_vec[i] = fire && (idx == IDX_W'(i));
  end

  // A request on a line already high is held one cycle so it gets its own edge
  always_comb begin
    req_vec   = hit_vec | pend_q;
    pulse_nxt = req_vec & ~pulse_q;
    pend_nxt  = req_vec & pulse_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse_q <= '0;
      pend_q  <= '0;
    end else begin
      pulse_q <= pulse_nxt;
      pend_q  <= pend_nxt;
    end
  end

  assign pulse = pulse_q;

  AST_PULSE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_q & $past(pulse_q)) == '0); // R7

  AST_HIT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec)); // R7

  AST_PEND_DRAINS: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pend_q) & ~pulse_q) == '0); // R10

endmodule

// File: rtl/msi_reg_file.sv
module msi_reg_file
  import msi_frame_pkg::*;
#(
  parameter int          BASE_SPI = 96,
  parameter int          NUM_SPI  = 64,
  parameter logic [31:0] ID_VALUE = 32'h0001_5A3B
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic              db_miss,
  output logic [DATA_W-1:0] rdata,
  output logic              ready,
  output logic              err_resp
);

  localparam logic [DATA_W-1:0] TYPE_WORD =
    {6'd0, 10'(BASE_SPI), 6'd0, 10'(NUM_SPI)};

  logic              rd_take;
  logic [DATA_W-1:0] rdata_nxt;
  logic [DATA_W-1:0] rdata_q;
  logic              ready_nxt;
  logic              ready_q;
  logic              err_nxt;
  logic              err_q;
  logic              sticky_nxt;
  logic              sticky_q;

  always_comb begin
    rd_take   = rd_en && !wr_en;
    ready_nxt = wr_en || rd_en;
    err_nxt   = db_miss;
    rdata_nxt = '0;
    if (rd_take) begin
      case (addr)
        OFF_TYPE:   rdata_nxt = TYPE_WORD;
        OFF_STATUS: rdata_nxt = {31'd0, sticky_q};
        OFF_IDENT:  rdata_nxt = ID_VALUE;
        default:    rdata_nxt = '0;
      endcase
    end
    sticky_nxt = sticky_q;
    if (db_miss) begin
      sticky_nxt = 1'b1;
    end else if (rd_take && (addr == OFF_STATUS)) begin
      sticky_nxt = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q  <= '0;
      ready_q  <= 1'b0;
      err_q    <= 1'b0;
      sticky_q <= 1'b0;
    end else begin
      rdata_q  <= rdata_nxt;
      ready_q  <= ready_nxt;
      err_q    <= err_nxt;
      sticky_q <= sticky_nxt;
    end
  end

  assign rdata    = rdata_q;
  assign ready    = ready_q;
  assign err_resp = err_q;

  AST_READY_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en || rd_en) |=> ready_q); // R11

  AST_IDLE_NO_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en || rd_en) |=> !ready_q); // R11

  AST_WR_NO_RDATA: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (rdata_q == '0)); // R11

  AST_ERR_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    db_miss |=> (err_q && ready_q)); // R8

  AST_STICKY_SET: assert property (@(posedge clk) disable iff (!rst_n)
    db_miss |=> sticky_q); // R9

  AST_TYPE_RSVD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_take && addr == OFF_TYPE) |=> (rdata_q[31:26] == '0 && rdata_q[15:10] == '0)); // R1

endmodule

// File: rtl/msi_spi_frame.sv
module msi_spi_frame
  import msi_frame_pkg::*;
#(
  parameter dec_mode_e   MODE     = DEC_ABSOLUTE,
  parameter int          BASE_SPI = 96,
  parameter int          NUM_SPI  = 64,
  parameter logic [31:0] ID_VALUE = 32'h0001_5A3B
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [12:0]        bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  output logic               bus_ready,
  output logic               bus_err,
  output logic [NUM_SPI-1:0] spi_pulse
);

  localparam int IDX_W = (NUM_SPI > 1) ? $clog2(NUM_SPI) : 1;

  if (BASE_SPI < SPI_LOW || NUM_SPI < 1 || BASE_SPI + NUM_SPI > SPI_HIGH) begin : g_bad_window
    $error("msi_spi_frame: SPI window out of legal limits");
  end

  logic             db_hit;
  logic             db_miss;
  logic [IDX_W-1:0] db_idx;

  msi_db_decode #(
    .MODE     (MODE),
    .BASE_SPI (BASE_SPI),
    .NUM_SPI  (NUM_SPI),
    .IDX_W    (IDX_W)
  ) u_decode (
    .wr_en   (bus_wr),
    .addr    (bus_addr),
    .wdata   (bus_wdata),
    .db_hit  (db_hit),
    .db_miss (db_miss),
    .db_idx  (db_idx)
  );

  msi_edge_gen #(
    .NUM_SPI (NUM_SPI),
    .IDX_W   (IDX_W)
  ) u_edges (
    .clk   (clk),
    .rst_n (rst_n),
    .fire  (db_hit),
    .idx   (db_idx),
    .pulse (spi_pulse)
  );

  msi_reg_file #(
    .BASE_SPI (BASE_SPI),
    .NUM_SPI  (NUM_SPI),
    .ID_VALUE (ID_VALUE)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (bus_wr),
    .rd_en    (bus_rd),
    .addr     (bus_addr),
    .db_miss  (db_miss),
    .rdata    (bus_rdata),
    .ready    (bus_ready),
    .err_resp (bus_err)
  );

  AST_HIT_MISS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(db_hit && db_miss)); // R8

  AST_IDX_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    db_hit |-> (int'(db_idx) < NUM_SPI)); // R7

  AST_MISS_NO_ERR_WITHOUT_WR: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> !bus_err); // R8

endmodule

// File: tb/test_msi_spi_frame.sv
`timescale 1ns/1ps
module test_msi_spi_frame;
  import msi_frame_pkg::*;

  localparam int          BASE = 96;
  localparam int          NUM  = 64;
  localparam logic [31:0] IDV  = 32'h0001_5A3B;
  localparam int          NV   = 4;

  logic        clk;
  logic        rst_n;
  logic        bus_wr;
  logic        bus_rd;
  logic [12:0] bus_addr;
  logic [31:0] bus_wdata;

  logic [31:0]    rdata_v [NV];
  logic           ready_v [NV];
  logic           err_v   [NV];
  logic [NUM-1:0] pulse_v [NV];

  int  checks;
  int  errors;
  bit  sticky_m [NV];

  initial clk = 1'b0;
  always #2 clk = ~clk;

  for (genvar v = 0; v < NV; v++) begin : g_var
    msi_spi_frame #(
      .MODE     (dec_mode_e'(v)),
      .BASE_SPI (BASE),
      .NUM_SPI  (NUM),
      .ID_VALUE (IDV)
    ) i_msi_spi_frame (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_wr    (bus_wr),
      .bus_rd    (bus_rd),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (rdata_v[v]),
      .bus_ready (ready_v[v]),
      .bus_err   (err_v[v]),
      .spi_pulse (pulse_v[v])
    );
  end

  task automatic chk(input bit ok, input string msg, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", msg, act, exp);
    end
  endtask

  // Expected decode of one write for variant v (R3-R8)
  task automatic model(input int v, input bit w, input logic [12:0] a, input logic [31:0] d,
                       output bit hit, output bit miss, output int idx);
    logic [32:0] s;
    bit db;
    if (v == 3) begin
      db = w && (a[2:0] == 3'd0);
      s  = 33'(a[12:3]) + 33'd32;
    end else begin
      db = w && (a == 13'h040);
      if (v == 0)      s = {1'b0, d};
      else if (v == 1) s = {1'b0, d} + 33'(BASE);
      else             s = {1'b0, d} + 33'd32;
    end
    hit  = db && (s >= 33'(BASE)) && (s < 33'(BASE + NUM));
    miss = db && !hit;
    idx  = hit ? int'(s - 33'(BASE)) : 0;
  endtask

  function automatic logic [31:0] rd_exp(input int v, input logic [12:0] a);
    case (a)
      13'h008: return {6'd0, 10'(BASE), 6'd0, 10'(NUM)};
      13'h00C: return {31'd0, sticky_m[v]};
      13'hFCC: return IDV;
      default: return 32'd0;
    endcase
  endfunction

  // One access followed by an idle cycle; every variant is checked
  task automatic do_op(input bit w, input bit r, input logic [12:0] a, input logic [31:0] d, input string req);
    bit hit [NV];
    bit miss [NV];
    int idx [NV];
    logic [31:0] re [NV];
    bit take_rd;
    take_rd = r && !w;
    for (int v = 0; v < NV; v++) begin
      model(v, w, a, d, hit[v], miss[v], idx[v]);
      re[v] = take_rd ? rd_exp(v, a) : 32'd0;
    end
    bus_wr = w; bus_rd = r; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    for (int v = 0; v < NV; v++) begin
      logic [NUM-1:0] ep;
      ep = hit[v] ? (NUM'(1) << idx[v]) : '0;
      chk(ready_v[v] == (w || r), $sformatf("R11 %s v%0d ready", req, v), 64'(ready_v[v]), 64'(w || r));
      chk(err_v[v] == miss[v], $sformatf("R8 %s v%0d err", req, v), 64'(err_v[v]), 64'(miss[v]));
      chk(pulse_v[v] == ep, $sformatf("R7 %s v%0d pulse", req, v), 64'(pulse_v[v]), 64'(ep));
      chk(rdata_v[v] == re[v], $sformatf("%s v%0d rdata", req, v), 64'(rdata_v[v]), 64'(re[v]));
      if (miss[v]) sticky_m[v] = 1'b1;
      else if (take_rd && a == 13'h00C) sticky_m[v] = 1'b0;
    end
    bus_wr = 1'b0; bus_rd = 1'b0;
    @(posedge clk); @(negedge clk);
    for (int v = 0; v < NV; v++) begin
      chk(pulse_v[v] == '0 && !ready_v[v], $sformatf("R7 %s v%0d idle after", req, v),
          64'(pulse_v[v]), 64'd0);
    end
  endtask

  task automatic note_sticky(input logic [12:0] a, input logic [31:0] d);
    bit h; bit m; int ix;
    for (int v = 0; v < NV; v++) begin
      model(v, 1'b1, a, d, h, m, ix);
      if (m) sticky_m[v] = 1'b1;
    end
  endtask

  // Back-to-back absolute writes, checked on variant 0 (R10)
  task automatic b2b(input int s1, input int s2, input string req);
    logic [NUM-1:0] e1, e2, e3;
    e1 = NUM'(1) << (s1 - BASE);
    if (s1 == s2) begin e2 = '0; e3 = e1; end
    else begin e2 = NUM'(1) << (s2 - BASE); e3 = '0; end
    bus_wr = 1'b1; bus_addr = 13'h040; bus_wdata = 32'(s1);
    note_sticky(13'h040, 32'(s1));
    @(posedge clk); @(negedge clk);
    chk(pulse_v[0] == e1, {req, " first"}, 64'(pulse_v[0]), 64'(e1));
    bus_wdata = 32'(s2);
    note_sticky(13'h040, 32'(s2));
    @(posedge clk); @(negedge clk);
    chk(pulse_v[0] == e2, {req, " second"}, 64'(pulse_v[0]), 64'(e2));
    bus_wr = 1'b0;
    @(posedge clk); @(negedge clk);
    chk(pulse_v[0] == e3, {req, " third"}, 64'(pulse_v[0]), 64'(e3));
    @(posedge clk); @(negedge clk);
  endtask

  initial begin
    bit done;
    done = 1'b0;
    fork
      begin
        repeat (200000) @(posedge clk);
        if (!done) begin
          checks++; errors++;
          $display("FAIL watchdog expired");
          $display("CHECKS %0d ERRORS %0d", checks, errors);
          $finish;
        end
      end
    join_none

    checks = 0; errors = 0;
    void'($urandom(32'd20240611));
    for (int v = 0; v < NV; v++) sticky_m[v] = 1'b0;
    rst_n = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    for (int v = 0; v < NV; v++) begin
      chk(!ready_v[v] && !err_v[v] && rdata_v[v] == '0 && pulse_v[v] == '0,
          $sformatf("R12 reset outputs v%0d", v), 64'(pulse_v[v]), 64'd0);
    end
    rst_n = 1'b1;
    @(negedge clk);

    do_op(1'b0, 1'b1, 13'h00C, 32'd0, "R12 status clear");
    do_op(1'b0, 1'b1, 13'h008, 32'd0, "R1 type");
    do_op(1'b0, 1'b1, 13'hFCC, 32'd0, "R2 ident");
    do_op(1'b0, 1'b1, 13'h100, 32'd0, "R2 unmapped");
    do_op(1'b1, 1'b0, 13'h008, 32'hFFFF_FFFF, "R2 write ro");
    do_op(1'b0, 1'b1, 13'h008, 32'd0, "R2 type unchanged");
    do_op(1'b1, 1'b0, 13'hFCC, 32'h1234_5678, "R2 write ident");
    do_op(1'b0, 1'b1, 13'hFCC, 32'd0, "R2 ident unchanged");
    do_op(1'b0, 1'b1, 13'h00C, 32'd0, "R9 status read clears");

    // Window edges under every encoding
    for (int k = 0; k < 4; k++) begin
      int s;
      s = (k == 0) ? BASE : (k == 1) ? BASE + NUM - 1 : (k == 2) ? BASE - 1 : BASE + NUM;
      do_op(1'b1, 1'b0, 13'h040, 32'(s), "R3 absolute");
      do_op(1'b1, 1'b0, 13'h040, 32'(s - BASE), "R4 base-relative");
      do_op(1'b1, 1'b0, 13'h040, 32'(s - 32), "R5 fixed-offset");
      do_op(1'b1, 1'b0, 13'((s - 32) << 3), 32'hDEAD_BEEF, "R6 address-only");
      do_op(1'b0, 1'b1, 13'h00C, 32'd0, "R9 status");
    end
    do_op(1'b1, 1'b0, 13'h221, 32'd100, "R6 misaligned");
    do_op(1'b1, 1'b0, 13'h044, 32'd100, "R6 other offset");
    do_op(1'b0, 1'b1, 13'h00C, 32'd0, "R9 status after ignored");
    do_op(1'b1, 1'b1, 13'h008, 32'd100, "R11 both strobes");
    do_op(1'b1, 1'b0, 13'h040, 32'd5000, "R8 far miss");
    do_op(1'b0, 1'b1, 13'h00C, 32'd0, "R9 sticky set");
    do_op(1'b0, 1'b1, 13'h00C, 32'd0, "R9 sticky cleared");

    b2b(BASE + 4, BASE + 5, "R10 distinct lines");
    b2b(BASE + 7, BASE + 7, "R10 same line");
    do_op(1'b0, 1'b1, 13'h00C, 32'd0, "R9 status after b2b");

    for (int n = 0; n < 400; n++) begin
      int s; int kind;
      s    = BASE - 6 + int'($urandom_range(0, NUM + 11));
      kind = int'($urandom_range(0, 5));
      case (kind)
        0: do_op(1'b1, 1'b0, 13'h040, 32'(s), "R3 random");
        1: do_op(1'b1, 1'b0, 13'h040, 32'(s - BASE), "R4 random");
        2: do_op(1'b1, 1'b0, 13'h040, 32'(s - 32), "R5 random");
        3: do_op(1'b1, 1'b0, 13'((s - 32) << 3), $urandom, "R6 random");
        4: begin
          logic [12:0] a;
          case ($urandom_range(0, 3))
            0: a = 13'h008;
            1: a = 13'h00C;
            2: a = 13'hFCC;
            default: a = 13'($urandom);
          endcase
          do_op(1'b0, 1'b1, a, 32'd0, "R2 random read");
        end
        default: do_op(1'b1, 1'b0, 13'($urandom), $urandom, "R6 random write");
      endcase
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule